// File: doc/BRIEF.md
# Conversion Start Sequencer

The block decides when a temperature converter begins a measurement. It has two modes, chosen by a run/stop control bit. With the bit high the block sits in standby and starts a conversion only when a one-shot command strobe arrives; once that conversion ends it goes back to standby. With the bit low it runs on its own: each finished conversion arms an interval timer, and the next conversion starts when the interval runs out. The timer counts ticks of a prescaled enable. The number of ticks is a base count shifted left by the rate setting, with the shift limited to a maximum.

A one-shot command has no effect while a conversion is in progress. In automatic mode a one-shot that arrives while the block is waiting between conversions starts a conversion at once and discards the partial interval. The next automatic start then waits a whole interval after that conversion finishes. The busy output covers the span of a conversion, so logic that may only act during a measurement, such as a sensor-fault check, can use it as its qualifier. The converter returns a single-cycle done pulse, and the bus decoder upstream delivers the strobes.

Top module: `conv_sequencer`

## Requirements
- R1: During reset and after it, busy and start are 0. While run/stop is 1 and no one-shot strobe arrives, no start pulse is produced.
- R2: When the block is idle in standby and a one-shot strobe is sampled at a clock edge, start is 1 in the next cycle. After that conversion's done pulse no further start occurs while run/stop stays 1.
- R3: Busy is 1 from the cycle in which start is 1 through the cycle in which done is sampled, and is 0 in the cycle after that.
- R4: A one-shot strobe sampled while busy is 1 causes no start. This includes a strobe in the same cycle as the done pulse.
- R5: If run/stop goes from 1 to 0 while the block is idle, start is 1 in the cycle after the 0 is sampled. Conversions then repeat without further commands.
- R6: In automatic mode the next start is 1 exactly N*PRE_DIV+1 cycles after the cycle in which done was high. N = BASE_TICKS << min(rate_sel, MAX_SHIFT). With the defaults (PRE_DIV=4, BASE_TICKS=2, MAX_SHIFT=4), rate_sel 0 gives a gap of 9 cycles, 2 gives 33, and 7 gives 129.
- R7: A one-shot strobe sampled in automatic mode between conversions gives start = 1 in the next cycle, and the following automatic start keeps the full R6 gap after that conversion's done. A strobe in the same cycle as the interval expiry yields exactly one start.
- R8: When run/stop is set to 1 in automatic mode, no further automatic start occurs. A conversion already in progress still completes, and busy then drops.
- R9: The start pulse is one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_stop | input | 1 | 1 = standby, 0 = automatic conversion |
| oneshot | input | 1 | One-shot command strobe, one cycle |
| rate_sel | input | RATE_W | Interval selector (shift of the base tick count) |
| conv_done | input | 1 | Converter done pulse |
| conv_start | output | 1 | Conversion start pulse |
| busy | output | 1 | Conversion in progress |

## Verification
Two pairs of events can coincide. A one-shot strobe can land in the same cycle as the timer expiry, and a one-shot strobe can land in the same cycle as the converter's done pulse. The bench takes the cycle of the most recent done pulse and computes from it the exact expiry cycle, or uses the done cycle itself, and drives the strobe there. It then counts start pulses. The expiry case must give exactly one start, at the cycle automatic pacing predicts. The done case must give no extra start: the block either stays quiet in standby or keeps the full automatic gap.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int PRE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    tick  = en && (pre_q == LAST);
    pre_d = pre_q;
    if (!en)       pre_d = '0;
    else if (tick) pre_d = '0;
    else           pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R6: the prescaler never runs past its division
  p_pre_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST);
  // R6: a disabled prescaler restarts from zero
  p_pre_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pre_q == '0);
endmodule

// File: rtl/rate_timer.sv
module rate_timer #(
  parameter int PRE_DIV    = 4,
  parameter int BASE_TICKS = 2,
  parameter int MAX_SHIFT  = 4,
  parameter int RATE_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              expire
);
  localparam int MAX_TICKS = BASE_TICKS << MAX_SHIFT;
  localparam int CW        = $clog2(MAX_TICKS + 1);

  logic          tick;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] interval;
  int unsigned   shift;

  tick_gen #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .tick (tick)
  );

  always_comb begin
    shift    = (int'(rate_sel) > MAX_SHIFT) ? MAX_SHIFT : int'(rate_sel);
    interval = CW'(BASE_TICKS) << shift;
    expire   = tick && (cnt_q >= interval - 1'b1);
    cnt_d    = cnt_q;
    if (!en)                 cnt_d = '0;
    else if (tick && !expire) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: tick count stays inside the largest interval
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAX_TICKS));
  // R6: expiry only while the timer is enabled
  p_expire_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> en);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_stop,
  input  logic oneshot,
  input  logic conv_done,
  input  logic expire,
  output logic start,
  output logic busy,
  output logic wait_en
);
  seq_state_e st_q, st_d;
  logic       start_q, start_d;

  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (oneshot || !run_stop) begin
          st_d    = ST_CONV;
          start_d = 1'b1;
        end
      end
      ST_WAIT: begin
        if (oneshot) begin
          st_d    = ST_CONV;
          start_d = 1'b1;
        end else if (run_stop) begin
          st_d = ST_IDLE;
        end else if (expire) begin
          st_d    = ST_CONV;
          start_d = 1'b1;
        end
      end
      ST_CONV: begin
        if (conv_done) st_d = run_stop ? ST_IDLE : ST_WAIT;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
    end
  end

  assign start   = start_q;
  assign busy    = (st_q == ST_CONV);
  assign wait_en = (st_q == ST_WAIT);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);
  p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_done) |=> !busy);
  p_ignore_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> (busy && !start));
  p_single_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && run_stop && !oneshot) |=> !start);
  p_oneshot_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && oneshot) |=> start);
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int PRE_DIV    = 4,
  parameter int BASE_TICKS = 2,
  parameter int MAX_SHIFT  = 4,
  parameter int RATE_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_stop,
  input  logic              oneshot,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              conv_done,
  output logic              conv_start,
  output logic              busy
);
  logic expire;
  logic wait_en;

  seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_stop (run_stop),
    .oneshot  (oneshot),
    .conv_done(conv_done),
    .expire   (expire),
    .start    (conv_start),
    .busy     (busy),
    .wait_en  (wait_en)
  );

  rate_timer #(
    .PRE_DIV   (PRE_DIV),
    .BASE_TICKS(BASE_TICKS),
    .MAX_SHIFT (MAX_SHIFT),
    .RATE_W    (RATE_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (wait_en),
    .rate_sel(rate_sel),
    .expire  (expire)
  );

  // R8: no automatic start while standby is requested and no command came
  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_en && run_stop && !oneshot) |=> !conv_start);
endmodule

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;
  localparam int LAT = 6;
  localparam int PD  = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run_stop, oneshot, conv_done;
  logic [2:0] rate_sel;
  logic       conv_start, busy;

  int cyc = 0, nstarts = 0, start_cyc = 0, done_cyc = 0, cd = 0;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  conv_sequencer u_conv_sequencer (
    .clk(clk), .rst_n(rst_n), .run_stop(run_stop), .oneshot(oneshot),
    .rate_sel(rate_sel), .conv_done(conv_done),
    .conv_start(conv_start), .busy(busy)
  );

  // monitor and fixed-latency converter stub
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (conv_start === 1'b1) begin
      nstarts   = nstarts + 1;
      start_cyc = cyc;
    end
    conv_done = 1'b0;
    if (cd > 0) begin
      cd = cd - 1;
      if (cd == 0) begin
        conv_done = 1'b1;
        done_cyc  = cyc;
      end
    end
    if (conv_start === 1'b1) cd = LAT;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic until_cyc(input int c);
    while (cyc < c) step();
  endtask

  task automatic pulse_os();
    oneshot = 1'b1; step(); oneshot = 1'b0;
  endtask

  task automatic wait_start();
    int n0 = nstarts;
    for (int i = 0; i < 2000 && nstarts == n0; i++) step();
    step();
    chk(conv_start == 1'b0, "R9 start width", conv_start, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; run_stop = 1'b1; oneshot = 1'b0; rate_sel = 3'd0;
    conv_done = 1'b0;
    repeat (3) step();
    chk(busy == 1'b0 && conv_start == 1'b0, "R1 reset", {busy, conv_start}, 0);
    rst_n = 1'b1;
    repeat (100) step();
    chk(nstarts == 0, "R1 standby idle", nstarts, 0);
  endtask

  task automatic t_oneshot_standby();
    int k, n0;
    n0 = nstarts; k = cyc;
    pulse_os();
    chk(start_cyc == k + 1 && nstarts == n0 + 1, "R2 start after strobe", start_cyc, k + 1);
    chk(busy == 1'b1, "R3 busy at start", busy, 1);
    pulse_os();
    until_cyc(start_cyc + LAT);
    chk(busy == 1'b1, "R3 busy at done", busy, 1);
    step();
    chk(busy == 1'b0, "R3 busy after done", busy, 0);
    repeat (100) step();
    chk(nstarts == n0 + 1, "R4 strobe while busy ignored / R2 back to standby", nstarts, n0 + 1);
  endtask

  task automatic t_done_coincide();
    int n0 = nstarts;
    pulse_os();
    until_cyc(start_cyc + LAT);
    pulse_os();
    repeat (60) step();
    chk(nstarts == n0 + 1, "R4 strobe with done", nstarts, n0 + 1);
  endtask

  task automatic t_auto(input logic [2:0] sel, input int gap);
    int k;
    rate_sel = sel; k = cyc;
    run_stop = 1'b0;
    wait_start();
    chk(start_cyc == k + 1, "R5 auto entry start", start_cyc, k + 1);
    wait_start();
    chk(start_cyc - done_cyc == gap, "R6 auto gap", start_cyc - done_cyc, gap);
    wait_start();
    chk(start_cyc - done_cyc == gap, "R6 auto gap repeat", start_cyc - done_cyc, gap);
  endtask

  task automatic t_stop_wait();
    int n0;
    until_cyc(start_cyc + LAT + 3);
    run_stop = 1'b1; n0 = nstarts;
    repeat (300) step();
    chk(nstarts == n0, "R8 stop during wait", nstarts, n0);
  endtask

  task automatic t_oneshot_auto();
    int d, n0;
    rate_sel = 3'd2; run_stop = 1'b0;
    wait_start();
    until_cyc(start_cyc + LAT + 1);
    d = done_cyc;
    until_cyc(d + 10);
    pulse_os();
    chk(start_cyc == d + 11, "R7 strobe between conversions", start_cyc, d + 11);
    wait_start();
    chk(start_cyc - done_cyc == 33, "R7 full interval after strobe", start_cyc - done_cyc, 33);
    until_cyc(start_cyc + LAT + 1);
    d = done_cyc; n0 = nstarts;
    until_cyc(d + 32);
    pulse_os();
    step();
    chk(start_cyc == d + 33 && nstarts == n0 + 1, "R7 strobe at expiry single start",
        nstarts - n0, 1);
  endtask

  task automatic t_stop_conv();
    int n0;
    run_stop = 1'b1;
    repeat (200) step();
    run_stop = 1'b0; n0 = nstarts;
    wait_start();
    run_stop = 1'b1;
    chk(busy == 1'b1, "R8 conversion continues", busy, 1);
    repeat (300) step();
    chk(nstarts == n0 + 1 && busy == 1'b0, "R8 stop during conversion", nstarts, n0 + 1);
  endtask

  initial begin
    t_reset();
    t_oneshot_standby();
    t_done_coincide();
    t_auto(3'd0, 2 * PD + 1);
    t_stop_wait();
    t_oneshot_auto();
    t_stop_wait();
    t_auto(3'd7, 32 * PD + 1);
    t_stop_conv();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule